// File: doc/BRIEF.md
# Bridging Short Injection Harness

This block holds a small binary up-counter and presents its value twice: once untouched as a reference copy, and once passed through a logic-level model of a short between two chosen bits. The short is resolved as wired-AND, wired-OR, or a strong-wins coupling in which one bit imposes its value on the other. A comparator flags any difference between the two copies in the same cycle. A sticky flag records that a difference has appeared at least once.

A testbench uses the harness to show when a short is invisible and when it shows up. A short is invisible while both bridged bits carry equal intended values. It shows up once the count drives them apart and the corrupted bit reaches the compared output. The short is applied only to the observed copy. The counter register always advances from its clean value, so the count sequence is the same with or without injection. The usual first candidate is a wired-AND short between count bits 1 and 2.

Top module: `bridge_harness`

## Requirements
- R1: While `rst` is high at a rising clock edge, the counter and `detected` are cleared to 0 at that edge.
- R2: At each rising edge outside reset, the counter advances by one when `cnt_en` is high and wraps from all ones to zero. It holds its value when `cnt_en` is low. `count_golden` shows the counter value.
- R3: With injection active and `kind` = 2'b01 (wired-AND), both selected bits of `count_faulty` equal the AND of their intended values.
- R4: With injection active and `kind` = 2'b10 (wired-OR), both selected bits of `count_faulty` equal the OR of their intended values.
- R5: With injection active and `kind` = 2'b11 (strong-wins), both selected bits take the intended value of bit `sel_a` when `dom_b` = 0, and of bit `sel_b` when `dom_b` = 1.
- R6: When the two selected bits carry equal intended values, `count_faulty` equals `count_golden` and `mismatch` is low.
- R7: Injection is inactive when `inj_en` is low, when `kind` = 2'b00, when `sel_a` equals `sel_b`, or when either index is not below W. While inactive, `count_faulty` equals `count_golden`.
- R8: `mismatch` is high in the same cycle exactly when `count_faulty` differs from `count_golden`. Bits other than the two selected ones are never altered.
- R9: `detected` goes high at the edge after a cycle with `mismatch` high and stays high. A high `clr_det` clears it at the next edge and overrides a simultaneous mismatch.
- R10: Injection never changes the counter sequence: `count_golden` follows R2 whatever the injection inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counter advance enable |
| inj_en | input | 1 | Short injection enable |
| sel_a | input | IW | Index of the first bridged bit |
| sel_b | input | IW | Index of the second bridged bit |
| kind | input | 2 | Short resolution: 00 none, 01 wired-AND, 10 wired-OR, 11 strong-wins |
| dom_b | input | 1 | Strong-wins side: 0 bit sel_a, 1 bit sel_b |
| clr_det | input | 1 | Clears the sticky detection flag |
| count_faulty | output | W | Counter value after the short is applied |
| count_golden | output | W | Fault-free counter value |
| mismatch | output | 1 | The two copies differ this cycle |
| detected | output | 1 | Sticky record of a past mismatch |

## Verification
The hardest situation to reach is one where the count drives the two chosen bits to opposite values while that bridge type, pair and strong side are selected. A detection then has to be cleared in the same cycle that a new mismatch arrives. The stimulus first lets the count run through a full wrap under the default wired-AND pair 1/2, so the states that hide the short and the states that expose it both occur. It then draws the pair, type, strong side and enables at random every cycle, with occasional clear pulses. Directed steps place a clear exactly on a mismatching count and apply a reset while the flag is set.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    typedef enum logic [1:0] {
        BR_NONE = 2'b00,
        BR_AND  = 2'b01,
        BR_OR   = 2'b10,
        BR_DOM  = 2'b11
    } bridge_kind_e;

    typedef struct packed {
        logic val_a;
        logic val_b;
    } bit_pair_t;

    // Value the shorted pair settles to.
    function automatic logic settle(bridge_kind_e k, bit_pair_t p, logic dom_b);
        logic r;
        case (k)
            BR_AND:  r = p.val_a & p.val_b;
            BR_OR:   r = p.val_a | p.val_b;
            BR_DOM:  r = dom_b ? p.val_b : p.val_a;
            default: r = p.val_a;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/hc_counter.sv
module hc_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    output logic [W-1:0] state
);
    always_ff @(posedge clk) begin
        if (rst)
            state <= '0;
        else if (en)
            state <= state + 1'b1;
    end
endmodule

// File: rtl/hc_bridge.sv
module hc_bridge
    import bridge_pkg::*;
#(
    parameter int W  = 4,
    parameter int IW = 2
) (
    input  logic [W-1:0]  v_in,
    input  logic          inj_en,
    input  logic [IW-1:0] sel_a,
    input  logic [IW-1:0] sel_b,
    input  bridge_kind_e  kind,
    input  logic          dom_b,
    output logic [W-1:0]  v_out
);
    logic      active;
    bit_pair_t pair;
    logic      shorted;

    always_comb begin
        active = inj_en && (kind != BR_NONE) && (sel_a != sel_b)
                 && (int'(sel_a) < W) && (int'(sel_b) < W);
        pair    = '0;
        for (int i = 0; i < W; i++) begin
            if (int'(sel_a) == i) pair.val_a = v_in[i];
            if (int'(sel_b) == i) pair.val_b = v_in[i];
        end
        shorted = settle(kind, pair, dom_b);
    end

    for (genvar g = 0; g < W; g++) begin : g_bit
        always_comb begin
            if (active && ((int'(sel_a) == g) || (int'(sel_b) == g)))
                v_out[g] = shorted;
            else
                v_out[g] = v_in[g];
        end
    end
endmodule

// File: rtl/hc_detect.sv
module hc_detect #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [W-1:0] observed,
    input  logic [W-1:0] reference,
    output logic         differ,
    output logic         sticky
);
    assign differ = (observed != reference);

    always_ff @(posedge clk) begin
        if (rst || clr)
            sticky <= 1'b0;
        else if (differ)
            sticky <= 1'b1;
    end
endmodule

// File: rtl/bridge_harness.sv
module bridge_harness
    import bridge_pkg::*;
#(
    parameter int W  = 4,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cnt_en,
    input  logic          inj_en,
    input  logic [IW-1:0] sel_a,
    input  logic [IW-1:0] sel_b,
    input  logic [1:0]    kind,
    input  logic          dom_b,
    input  logic          clr_det,
    output logic [W-1:0]  count_faulty,
    output logic [W-1:0]  count_golden,
    output logic          mismatch,
    output logic          detected
);
    logic [W-1:0] cnt_q;

    hc_counter #(.W(W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .en    (cnt_en),
        .state (cnt_q)
    );

    hc_bridge #(.W(W), .IW(IW)) u_short (
        .v_in   (cnt_q),
        .inj_en (inj_en),
        .sel_a  (sel_a),
        .sel_b  (sel_b),
        .kind   (bridge_kind_e'(kind)),
        .dom_b  (dom_b),
        .v_out  (count_faulty)
    );

    hc_detect #(.W(W)) u_det (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr_det),
        .observed  (count_faulty),
        .reference (cnt_q),
        .differ    (mismatch),
        .sticky    (detected)
    );

    assign count_golden = cnt_q;
endmodule

// File: rtl/bridge_harness_chk.sv
module bridge_harness_chk #(
    parameter int W  = 4,
    parameter int IW = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          cnt_en,
    input logic          inj_en,
    input logic [IW-1:0] sel_a,
    input logic [IW-1:0] sel_b,
    input logic [1:0]    kind,
    input logic          dom_b,
    input logic          clr_det,
    input logic [W-1:0]  count_faulty,
    input logic [W-1:0]  count_golden,
    input logic          mismatch,
    input logic          detected
);
    logic past_rst = 1'b0;
    logic pair_ok;
    logic live;

    assign pair_ok = (int'(sel_a) < W) && (int'(sel_b) < W) && (sel_a != sel_b);
    assign live    = inj_en && pair_ok;

    always_ff @(posedge clk) begin
        past_rst <= rst;
        if (past_rst)
            a_r1_reset_clear: assert (count_golden == '0 && !detected);
    end

    a_r2_advance: assert property (@(posedge clk) disable iff (rst)
        cnt_en |=> count_golden == W'($past(count_golden) + 1'b1));

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> $stable(count_golden));

    a_r3_wired_and: assert property (@(posedge clk) disable iff (rst)
        (live && kind == 2'b01) |->
        (count_faulty[sel_a] == (count_golden[sel_a] & count_golden[sel_b]) &&
         count_faulty[sel_b] == (count_golden[sel_a] & count_golden[sel_b])));

    a_r4_wired_or: assert property (@(posedge clk) disable iff (rst)
        (live && kind == 2'b10) |->
        (count_faulty[sel_a] == (count_golden[sel_a] | count_golden[sel_b]) &&
         count_faulty[sel_b] == (count_golden[sel_a] | count_golden[sel_b])));

    a_r5_strong_wins: assert property (@(posedge clk) disable iff (rst)
        (live && kind == 2'b11) |->
        (count_faulty[sel_a] == (dom_b ? count_golden[sel_b] : count_golden[sel_a]) &&
         count_faulty[sel_b] == (dom_b ? count_golden[sel_b] : count_golden[sel_a])));

    a_r6_equal_hidden: assert property (@(posedge clk) disable iff (rst)
        (pair_ok && count_golden[sel_a] == count_golden[sel_b]) |-> !mismatch);

    a_r7_inactive: assert property (@(posedge clk) disable iff (rst)
        (!inj_en || kind == 2'b00 || sel_a == sel_b) |-> count_faulty == count_golden);

    a_r8_two_bits_max: assert property (@(posedge clk) disable iff (rst)
        $countones(count_faulty ^ count_golden) <= 2);

    a_r9_set: assert property (@(posedge clk) disable iff (rst)
        (mismatch && !clr_det) |=> detected);

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (detected && !clr_det) |=> detected);

    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        clr_det |=> !detected);
endmodule

bind bridge_harness bridge_harness_chk #(.W(W), .IW(IW)) u_chk (.*);

// File: tb/bridge_harness_test.sv
`timescale 1ns/1ps
module bridge_harness_test;
    localparam int W  = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst, cnt_en, inj_en, dom_b, clr_det;
    logic [IW-1:0] sel_a, sel_b;
    logic [1:0]    kind;
    logic [W-1:0]  count_faulty, count_golden;
    logic          mismatch, detected;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [W-1:0] m_cnt;
    logic         m_det;

    always #2 clk = ~clk;

    bridge_harness #(.W(W), .IW(IW)) uut (.*);

    function automatic logic [W-1:0] exp_faulty(logic [W-1:0] v, int a, int b,
                                               logic [1:0] k, logic sb, logic inj);
        logic [W-1:0] r = v;
        logic x;
        if (inj && k != 2'b00 && a != b && a < W && b < W) begin
            if (k == 2'b01)      x = v[a] & v[b];
            else if (k == 2'b10) x = v[a] | v[b];
            else                 x = sb ? v[b] : v[a];
            r[a] = x;
            r[b] = x;
        end
        return r;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // One cycle: drive, check combinational outputs, advance the model.
    task automatic step(logic en, logic inj, int a, int b, logic [1:0] k,
                        logic sb, logic clr);
        logic [W-1:0] ef;
        string tag;
        @(negedge clk);
        rst = 1'b0; cnt_en = en; inj_en = inj; sel_a = IW'(a); sel_b = IW'(b);
        kind = k; dom_b = sb; clr_det = clr;
        #1;
        ef = exp_faulty(m_cnt, a, b, k, sb, inj);
        if (!inj || k == 2'b00 || a == b) tag = "R7";
        else if (m_cnt[a] == m_cnt[b])    tag = "R6";
        else if (k == 2'b01)              tag = "R3";
        else if (k == 2'b10)              tag = "R4";
        else                              tag = "R5";
        chk("R2/R10 golden", 32'(count_golden), 32'(m_cnt));
        chk({tag, " faulty"}, 32'(count_faulty), 32'(ef));
        chk("R8 mismatch", 32'(mismatch), 32'(ef != m_cnt));
        chk("R9 detected", 32'(detected), 32'(m_det));
        @(posedge clk);
        if (clr)             m_det = 1'b0;
        else if (ef != m_cnt) m_det = 1'b1;
        if (en) m_cnt = m_cnt + 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cnt_en = 1'b1; clr_det = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0; cnt_en = 1'b0;
        m_cnt = '0; m_det = 1'b0;
        #1;
        chk("R1 count", 32'(count_golden), 0);
        chk("R1 detected", 32'(detected), 0);
    endtask

    initial begin
        #(4 * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1; cnt_en = 0; inj_en = 0; sel_a = 0; sel_b = 0;
        kind = 0; dom_b = 0; clr_det = 0;
        m_cnt = '0; m_det = 1'b0;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        do_reset();

        // Default pair 1/2, wired-AND, full wrap: hidden then exposed (R3, R6, R9).
        for (int i = 0; i < 18; i++) step(1, 1, 1, 2, 2'b01, 0, 0);
        // Hold with count fixed (R2).
        for (int i = 0; i < 3; i++) step(0, 1, 1, 2, 2'b01, 0, 0);
        // Clear the flag (R9).
        step(0, 0, 1, 2, 2'b01, 0, 1);
        // Walk to count 2 (bits 1/2 apart) and clear while mismatching (R9 override).
        while (m_cnt != 4'd2) step(1, 0, 0, 0, 2'b00, 0, 1);
        step(0, 1, 1, 2, 2'b01, 0, 1);
        step(0, 1, 1, 2, 2'b01, 0, 0);
        // Same index and no-type both inactive (R7).
        step(0, 1, 1, 1, 2'b10, 0, 1);
        step(0, 1, 1, 2, 2'b00, 0, 0);
        // Wired-OR and both strong sides on count 2 (R4, R5).
        step(0, 1, 1, 2, 2'b10, 0, 0);
        step(0, 1, 1, 2, 2'b11, 0, 0);
        step(0, 1, 1, 2, 2'b11, 1, 0);
        // Reset while the flag is set (R1).
        do_reset();

        // Constrained random (R2..R10).
        for (int i = 0; i < 600; i++) begin
            step($urandom_range(0, 3) != 0, $urandom_range(0, 4) != 0,
                 $urandom_range(0, W - 1), $urandom_range(0, W - 1),
                 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                 $urandom_range(0, 15) == 0);
        end
        do_reset();
        finish_run();
    end
endmodule